// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Bridge

This block turns bus reads and writes aimed at a window of serial flash into single-bit SPI transactions. It serves a small number of chip selects. Each one has its own control word with an access mode, a command byte, a two-part dummy count and a stop bit. The stop bit drives that chip select's active-low line directly. A shared write-permission word and a shared long-address word hold one bit per chip select.

In the three framed modes (read, fast read and write) the bridge builds each transaction itself. It selects the device, sends the command, sends the address most significant byte first, optionally sends dummy bytes, then moves 1, 2 or 4 data bytes and deselects. In user mode the bridge only moves raw bytes and never touches the select line, so software can hold a device selected across several accesses by writing the stop bit itself. Illegal accesses are refused with no SPI activity, and every response carries an error flag.

Top module: `spi_flash_bridge`

## Requirements
- R1: After reset every `spi_cs_n` is high, `spi_sclk` is low, `req_ready` is high, writes are disabled for every chip select and every control word is in read mode (mode 0) with its stop bit set.
- R2: The control word layout is: mode in bits [2:0], stop in bit 3, dummy low in bits [5:4], dummy high in bit 6, command in bits [15:8]. Mode codes are 0 read, 1 fast read, 2 write and 3 user. A request to a chip select whose mode is 4 to 7 gets an error response, with no SCLK edge and no select change.
- R3: In user mode a bus read sends 0x00 bytes. The bytes received are packed little-endian, so byte i lands in `rsp_rdata[8i+7:8i]`, and the chip-select line is left as it is.
- R4: In user mode a bus write sends `req_wdata` least significant byte first and leaves the chip-select line as it is.
- R5: `spi_cs_n[i]` always equals the stop bit of control word i. A framed transaction clears that bit before the first byte, keeps it clear through every phase, and sets it again after the last data byte.
- R6: The command byte is control bits [15:8]. In read mode a zero command is sent as 0x03. In fast-read or write mode a zero command is sent as 0x00 and the response is flagged as an error.
- R7: The address is sent most significant byte first. It is 4 bytes when bit cs of the long-address word is set and 3 bytes otherwise.
- R8: Only in fast-read mode, N = {bit 6, bits [5:4]} dummy bytes of 0xFF (8N SCLK cycles) follow the address. MOSI is high on every SCLK high phase during these bytes.
- R9: A bus write to chip select cs needs bit 16+cs of the permission word, in any mode. Without it the request gets an error response and causes no SPI activity.
- R10: A framed access whose offset is 2^SEG_LOG2 or more is reduced modulo 2^SEG_LOG2, carried out, and flagged as an error.
- R11: A bus write in read or fast-read mode, or a bus read in write mode, gets an error response and causes no SPI activity.
- R12: SPI mode 0. SCLK idles low and each high phase lasts exactly one clock, so SCLK is at most clk/2. MISO is sampled at the end of the high phase. `req_ready` is low while a request is being served, and `rsp_valid` is a one-cycle pulse.
- R13: `req_size` sets the data length: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: 0 permission, 1 long-address, 2+i control word i |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bridge idle, request accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | CSW | Chip select index |
| req_addr | input | 32 | Flash offset |
| req_size | input | 2 | Data length code |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access flagged as an error |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
The hardest state to reach is a device that stays selected across several bus accesses. The bridge never creates that state itself. It exists only when software clears a stop bit while the control word is in user mode. The bench gets there by register writes between accesses: it sets user mode with the stop bit set, clears the stop bit, sends a user-mode write, and then checks that the select line is still low. Fast-read framing is the other hard case, because the dummy count only shows up as a gap of 0xFF bytes. The bench sets both halves of the dummy field and counts every SCLK edge together with the bytes seen by its device model.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam logic [2:0] MODE_READ  = 3'd0;
    localparam logic [2:0] MODE_FAST  = 3'd1;
    localparam logic [2:0] MODE_WRITE = 3'd2;
    localparam logic [2:0] MODE_USER  = 3'd3;

    localparam int CTRL_W    = 16;
    localparam int STOP_BIT  = 3;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0008;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_RESP
    } seq_state_e;

    function automatic logic [2:0] ctl_mode(input logic [CTRL_W-1:0] c);
        return c[2:0];
    endfunction

    function automatic logic [7:0] ctl_cmd(input logic [CTRL_W-1:0] c);
        return c[15:8];
    endfunction

    function automatic logic [2:0] ctl_dummy(input logic [CTRL_W-1:0] c);
        return {c[6], c[5:4]};
    endfunction

endpackage

// File: rtl/sfb_shifter.sv
module sfb_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    typedef struct packed {
        logic       busy;
        logic       sclk;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.sclk = 1'b0;
            d.cnt  = 3'd0;
            d.sh   = tx_byte;
        end else if (q.busy) begin
            if (!q.sclk) begin
                d.sclk = 1'b1;
            end else begin
                d.sclk = 1'b0;
                d.sh   = {q.sh[6:0], miso};
                d.cnt  = q.cnt + 3'd1;
                if (q.cnt == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done    = q.done;
    assign rx_byte = q.sh;
    assign sclk    = q.sclk;
    assign mosi    = q.busy ? q.sh[7] : 1'b0;

    // R12
    sclk_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

endmodule

// File: rtl/sfb_regs.sv
module sfb_regs
    import sfb_pkg::*;
#(
    parameter int NCS       = 2,
    parameter int W_EN_BASE = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [3:0]                 wr_sel,
    input  logic [31:0]                wr_data,
    input  logic [NCS-1:0]             stop_clr,
    input  logic [NCS-1:0]             stop_set,
    output logic [NCS-1:0][CTRL_W-1:0] ctrl,
    output logic [NCS-1:0]             wen,
    output logic [NCS-1:0]             ext
);
    typedef struct packed {
        logic [NCS-1:0][CTRL_W-1:0] ctrl;
        logic [NCS-1:0]             wen;
        logic [NCS-1:0]             ext;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_sel == 4'd0) d.wen = wr_data[W_EN_BASE +: NCS];
            if (wr_sel == 4'd1) d.ext = wr_data[NCS-1:0];
            for (int i = 0; i < NCS; i++) begin
                if (wr_sel == 4'(i + 2)) d.ctrl[i] = wr_data[CTRL_W-1:0];
            end
        end
        for (int i = 0; i < NCS; i++) begin
            if (stop_clr[i]) d.ctrl[i][STOP_BIT] = 1'b0;
            if (stop_set[i]) d.ctrl[i][STOP_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.wen <= '0;
            q.ext <= '0;
            for (int i = 0; i < NCS; i++) q.ctrl[i] <= CTRL_RESET;
        end else begin
            q <= d;
        end
    end

    assign ctrl = q.ctrl;
    assign wen  = q.wen;
    assign ext  = q.ext;

    for (genvar g = 0; g < NCS; g++) begin : g_chk
        // R5
        stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stop_set[g] |=> ctrl[g][STOP_BIT]);
    end

endmodule

// File: rtl/spi_flash_bridge.sv
module spi_flash_bridge
    import sfb_pkg::*;
#(
    parameter int NCS       = 2,
    parameter int SEG_LOG2  = 20,
    parameter int W_EN_BASE = 16,
    localparam int CSW      = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [3:0]     cfg_sel,
    input  logic [31:0]    cfg_wdata,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [CSW-1:0] req_cs,
    input  logic [31:0]    req_addr,
    input  logic [1:0]     req_size,
    input  logic [31:0]    req_wdata,
    output logic           rsp_valid,
    output logic [31:0]    rsp_rdata,
    output logic           rsp_err,
    output logic           spi_sclk,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);
    localparam logic [31:0] SEG_MASK = (32'd1 << SEG_LOG2) - 32'd1;

    typedef struct packed {
        seq_state_e     st;
        logic [CSW-1:0] cs;
        logic           wr;
        logic           framed;
        logic           four;
        logic [1:0]     nb_m1;
        logic [2:0]     ndum;
        logic [2:0]     cnt;
        logic [31:0]    addr;
        logic [31:0]    wdata;
        logic [31:0]    rdata;
        logic           err;
    } seq_t;

    seq_t q, d;

    logic [NCS-1:0][CTRL_W-1:0] ctrl_w;
    logic [NCS-1:0]             wen_w, ext_w, clr_w, set_w;
    logic                       sh_start, sh_done;
    logic [7:0]                 sh_tx, sh_rx;

    function automatic logic [7:0] addr_byte(input logic [31:0] a, input logic four,
                                             input logic [1:0] k);
        logic [1:0] pos;
        pos = (four ? 2'd3 : 2'd2) - k;
        return a[{pos, 3'b000} +: 8];
    endfunction

    function automatic logic [7:0] data_byte(input logic wr, input logic [31:0] w,
                                             input logic [1:0] k);
        return wr ? w[{k, 3'b000} +: 8] : 8'h00;
    endfunction

    sfb_regs #(.NCS(NCS), .W_EN_BASE(W_EN_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
        .stop_clr(clr_w), .stop_set(set_w), .ctrl(ctrl_w), .wen(wen_w), .ext(ext_w)
    );

    sfb_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
        .done(sh_done), .rx_byte(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    always_comb begin
        logic [CTRL_W-1:0] c;
        logic [2:0]        md;
        logic              bad;
        logic [7:0]        cmd;
        d        = q;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        clr_w    = '0;
        set_w    = '0;
        c        = ctrl_w[req_cs];
        md       = ctl_mode(c);
        cmd      = ctl_cmd(c);
        bad      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (md > MODE_USER) bad = 1'b1;
                    if ((md == MODE_READ || md == MODE_FAST) && req_write) bad = 1'b1;
                    if (md == MODE_WRITE && !req_write) bad = 1'b1;
                    if (req_write && !wen_w[req_cs]) bad = 1'b1;
                    d.cs     = req_cs;
                    d.wr     = req_write;
                    d.nb_m1  = (req_size == 2'd0) ? 2'd0 : (req_size == 2'd1) ? 2'd1 : 2'd3;
                    d.wdata  = req_wdata;
                    d.rdata  = '0;
                    d.cnt    = 3'd0;
                    d.addr   = req_addr & SEG_MASK;
                    d.four   = ext_w[req_cs];
                    d.ndum   = (md == MODE_FAST) ? ctl_dummy(c) : 3'd0;
                    d.framed = (md != MODE_USER);
                    if (bad) begin
                        d.st  = ST_RESP;
                        d.err = 1'b1;
                    end else if (md == MODE_USER) begin
                        d.st     = ST_DATA;
                        d.err    = 1'b0;
                        sh_start = 1'b1;
                        sh_tx    = data_byte(req_write, req_wdata, 2'd0);
                    end else begin
                        d.st  = ST_CMD;
                        d.err = |(req_addr & ~SEG_MASK);
                        if (cmd == 8'h00) begin
                            if (md == MODE_READ) cmd = 8'h03;
                            else                 d.err = 1'b1;
                        end
                        sh_start       = 1'b1;
                        sh_tx          = cmd;
                        clr_w[req_cs]  = 1'b1;
                    end
                end
            end
            ST_CMD: begin
                if (sh_done) begin
                    d.st     = ST_ADDR;
                    d.cnt    = 3'd0;
                    sh_start = 1'b1;
                    sh_tx    = addr_byte(q.addr, q.four, 2'd0);
                end
            end
            ST_ADDR: begin
                if (sh_done) begin
                    sh_start = 1'b1;
                    if (q.cnt[1:0] != (q.four ? 2'd3 : 2'd2)) begin
                        d.cnt = q.cnt + 3'd1;
                        sh_tx = addr_byte(q.addr, q.four, d.cnt[1:0]);
                    end else if (q.ndum != 3'd0) begin
                        d.st  = ST_DUMMY;
                        d.cnt = 3'd0;
                        sh_tx = 8'hFF;
                    end else begin
                        d.st  = ST_DATA;
                        d.cnt = 3'd0;
                        sh_tx = data_byte(q.wr, q.wdata, 2'd0);
                    end
                end
            end
            ST_DUMMY: begin
                if (sh_done) begin
                    sh_start = 1'b1;
                    if (q.cnt == q.ndum - 3'd1) begin
                        d.st  = ST_DATA;
                        d.cnt = 3'd0;
                        sh_tx = data_byte(q.wr, q.wdata, 2'd0);
                    end else begin
                        d.cnt = q.cnt + 3'd1;
                        sh_tx = 8'hFF;
                    end
                end
            end
            ST_DATA: begin
                if (sh_done) begin
                    if (!q.wr) d.rdata[{q.cnt[1:0], 3'b000} +: 8] = sh_rx;
                    if (q.cnt[1:0] == q.nb_m1) begin
                        d.st = ST_RESP;
                        if (q.framed) set_w[q.cs] = 1'b1;
                    end else begin
                        d.cnt    = q.cnt + 3'd1;
                        sh_start = 1'b1;
                        sh_tx    = data_byte(q.wr, q.wdata, d.cnt[1:0]);
                    end
                end
            end
            ST_RESP: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = (q.st == ST_RESP);
    assign rsp_rdata = q.rdata;
    assign rsp_err   = q.err;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign spi_cs_n[g] = ctrl_w[g][STOP_BIT];
    end

    // R5
    framed_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.framed && (q.st == ST_CMD || q.st == ST_ADDR || q.st == ST_DUMMY || q.st == ST_DATA))
        |-> !spi_cs_n[q.cs]);

    // R8
    dummy_mosi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DUMMY && spi_sclk) |-> spi_mosi);

    // R9
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !wen_w[req_cs]) |=> (rsp_valid && rsp_err));

    // R2
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ctl_mode(ctrl_w[req_cs]) > MODE_USER) |=> (rsp_valid && rsp_err));

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/spi_flash_bridge_test.sv
`timescale 1ns/1ps
module spi_flash_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [0:0]  req_cs = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [1:0]  spi_cs_n;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    spi_flash_bridge uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Device model: captures MOSI on rising SCLK; MISO returns 0xA0 + byte index
    logic [7:0] log_b [0:31];
    int         log_n = 0;
    int         ibit = 0;
    int         obit = 0;
    int         sclk_cnt = 0;
    int         fall0 = 0;
    int         fall1 = 0;
    logic [7:0] rx_sh = '0;
    logic [7:0] out_b;

    assign out_b    = 8'hA0 + 8'(obit / 8);
    assign spi_miso = out_b[7 - (obit % 8)];

    always @(posedge spi_sclk) begin
        rx_sh = {rx_sh[6:0], spi_mosi};
        ibit++;
        sclk_cnt++;
        if (ibit == 8) begin
            if (log_n < 32) log_b[log_n] = rx_sh;
            log_n++;
            ibit = 0;
        end
    end
    always @(negedge spi_sclk) obit++;
    always @(negedge spi_cs_n[0]) fall0++;
    always @(negedge spi_cs_n[1]) fall1++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0; ibit = 0; obit = 0; sclk_cnt = 0; fall0 = 0; fall1 = 0;
    endtask

    task automatic cfg(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    logic mid_ready;
    logic post_valid;

    task automatic do_req(input logic wr, input logic cs, input logic [31:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er);
        clear_log();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cs = cs; req_addr = a;
        req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        mid_ready = req_ready;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        er = rsp_err;
        @(negedge clk);
        post_valid = rsp_valid;
    endtask

    task automatic chk_bytes(input string tag, input logic [7:0] exp [], input int n);
        chk({tag, " count"}, 32'(log_n), 32'(n));
        for (int i = 0; i < n; i++) chk({tag, " byte"}, {24'h0, log_b[i]}, {24'h0, exp[i]});
    endtask

    task automatic t_reset();
        chk("R1 cs_n", {30'h0, spi_cs_n}, 32'h3);
        chk("R1 sclk", {31'h0, spi_sclk}, 32'h0);
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
    endtask

    task automatic t_read_default();
        logic [31:0] rd; logic er;
        do_req(1'b0, 1'b0, 32'h0001_2345, 2'd2, 32'h0, rd, er);
        chk_bytes("R6 R7 R13 read", '{8'h03, 8'h01, 8'h23, 8'h45, 8'h00, 8'h00, 8'h00, 8'h00}, 8);
        chk("R3 R13 read data", rd, 32'hA7A6_A5A4);
        chk("R6 read err", {31'h0, er}, 32'h0);
        chk("R5 cs0 fell", 32'(fall0), 32'd1);
        chk("R5 cs released", {30'h0, spi_cs_n}, 32'h3);
        chk("R12 ready busy", {31'h0, mid_ready}, 32'h0);
        chk("R12 rsp pulse", {31'h0, post_valid}, 32'h0);
    endtask

    task automatic t_four_byte();
        logic [31:0] rd; logic er;
        cfg(4'd1, 32'h2);
        cfg(4'd3, 32'h1308);
        do_req(1'b0, 1'b1, 32'h000A_BCDE, 2'd0, 32'h0, rd, er);
        chk_bytes("R7 four", '{8'h13, 8'h00, 8'h0A, 8'hBC, 8'hDE, 8'h00}, 6);
        chk("R13 one byte", rd, 32'h0000_00A5);
        chk("R5 cs1 only", 32'(fall1 * 10 + fall0), 32'd10);
    endtask

    task automatic t_fast();
        logic [31:0] rd; logic er;
        cfg(4'd2, 32'h0B59);
        do_req(1'b0, 1'b0, 32'h10, 2'd1, 32'h0, rd, er);
        chk_bytes("R8 fast", '{8'h0B, 8'h00, 8'h00, 8'h10, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                               8'h00, 8'h00}, 11);
        chk("R8 fast data", rd, 32'h0000_AAA9);
        chk("R12 sclk edges", 32'(sclk_cnt), 32'd88);
        cfg(4'd2, 32'h0009);
        do_req(1'b0, 1'b0, 32'h10, 2'd0, 32'h0, rd, er);
        chk("R6 zero cmd err", {31'h0, er}, 32'h1);
        chk("R6 zero cmd byte", {24'h0, log_b[0]}, 32'h0);
        chk("R8 no dummy count", 32'(log_n), 32'd5);
    endtask

    task automatic t_write();
        logic [31:0] rd; logic er;
        cfg(4'd2, 32'h020A);
        do_req(1'b1, 1'b0, 32'h100, 2'd2, 32'h4433_2211, rd, er);
        chk("R9 protect err", {31'h0, er}, 32'h1);
        chk("R9 protect quiet", 32'(sclk_cnt + fall0), 32'h0);
        cfg(4'd0, 32'h0001_0000);
        do_req(1'b1, 1'b0, 32'h100, 2'd2, 32'h4433_2211, rd, er);
        chk_bytes("R4 R5 write", '{8'h02, 8'h00, 8'h01, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44}, 8);
        chk("R9 write ok", {31'h0, er}, 32'h0);
        do_req(1'b0, 1'b0, 32'h100, 2'd0, 32'h0, rd, er);
        chk("R11 mismatch err", {31'h0, er}, 32'h1);
        chk("R11 mismatch quiet", 32'(sclk_cnt + fall0), 32'h0);
    endtask

    task automatic t_bad_mode();
        logic [31:0] rd; logic er;
        cfg(4'd2, 32'h000D);
        do_req(1'b0, 1'b0, 32'h0, 2'd0, 32'h0, rd, er);
        chk("R2 bad mode err", {31'h0, er}, 32'h1);
        chk("R2 bad mode quiet", 32'(sclk_cnt + fall0), 32'h0);
        chk("R2 cs idle", {30'h0, spi_cs_n}, 32'h3);
    endtask

    task automatic t_segment();
        logic [31:0] rd; logic er;
        cfg(4'd2, 32'h0008);
        do_req(1'b0, 1'b0, 32'h0012_3456, 2'd0, 32'h0, rd, er);
        chk_bytes("R10 wrap", '{8'h03, 8'h02, 8'h34, 8'h56, 8'h00}, 5);
        chk("R10 wrap err", {31'h0, er}, 32'h1);
    endtask

    task automatic t_user();
        logic [31:0] rd; logic er;
        cfg(4'd2, 32'h000B);
        do_req(1'b0, 1'b0, 32'h0, 2'd3, 32'h0, rd, er);
        chk_bytes("R3 user read", '{8'h00, 8'h00, 8'h00, 8'h00}, 4);
        chk("R3 user data", rd, 32'hA3A2_A1A0);
        chk("R3 cs unchanged", 32'(fall0) + {31'h0, ~spi_cs_n[0]}, 32'h0);
        cfg(4'd2, 32'h0003);
        chk("R5 cs follows stop", {31'h0, spi_cs_n[0]}, 32'h0);
        do_req(1'b1, 1'b0, 32'h0, 2'd1, 32'h0000_BEEF, rd, er);
        chk_bytes("R4 user write", '{8'hEF, 8'hBE}, 2);
        chk("R4 cs held", {31'h0, spi_cs_n[0]}, 32'h0);
        cfg(4'd2, 32'h000B);
        chk("R5 cs dropped", {31'h0, spi_cs_n[0]}, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_default();
        t_four_byte();
        t_fast();
        t_write();
        t_bad_mode();
        t_segment();
        t_user();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule